// File: doc/BRIEF.md
# GPIO Event Controller

This block manages up to 32 general-purpose lines and turns activity on their inputs into interrupt requests. Every line owns one 32-bit control word on a simple APB-style register bus. The word turns the pad driver on or off, gates the input path, arms the interrupt and picks one of five trigger conditions: high level, low level, rising edge, falling edge or either edge.

Each input first crosses into the block clock through two flops. Edges are then found by comparing the synchronised sample with the sample one clock older. A line that meets its trigger latches a pending flag. Software reads all pending flags at once from a shared status word and clears chosen flags by writing ones to them.

The pending flags leave the block in two forms: a vector with one bit per line, for a downstream router that can steer lines individually, and a single summary request that is high while any flag is set.

Top module: `gpio_event_unit`

## Requirements
- R1: Address map, byte addressed on an 8-bit address. The control word of line i is at 4*i. The status word is at 0x80 and its bit i is the pending flag of line i. Reads of any other address return 0. Accesses take effect when psel and penable are both high; prdata is valid in that cycle.
- R2: After reset, every control word, every pending flag, padOe, irqVec and irqAny are 0.
- R3: Fields of a control word: bit 0 output enable, bit 1 input enable, bit 2 output buffer enable, bit 3 interrupt enable, bits 7:5 trigger code. Writing 0xFFFFFFFF reads back as 0x000000EF. All other bits read 0.
- R4: padOe[i] is 1 exactly when bits 0 and 2 of the control word of line i are both 1.
- R5: The pending flag of a line is never set unless bit 3 (interrupt enable) and bit 1 (input enable) of its control word are both 1.
- R6: Writing the status word clears each pending flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R7: Trigger code 2 sets pending on a rising input, code 3 on a falling input, code 4 on either. An input change applied between clock edges shows in irqVec after the third rising clock edge, and not after the second.
- R8: Trigger codes 5, 6 and 7 never set pending, whatever the input does.
- R9: Code 0 (level high) and code 1 (level low) set pending on every clock while the level is present, so a clear made while the level lasts has no visible effect. When a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R10: irqVec[i] equals the pending flag of line i, and irqAny is the OR of all the pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| padIn | input | NUM_LINES | Raw pad inputs, asynchronous |
| padOe | output | NUM_LINES | Pad driver enables |
| irqVec | output | NUM_LINES | Per-line pending flags |
| irqAny | output | 1 | OR of all pending flags |

## Verification
A stale synchroniser or edge-history flop shows at irqVec as an interrupt that comes one cycle early, one cycle late, or on the wrong edge. The bench therefore samples the vector after the second and after the third clock edge following each input change. A clear that loses to a set, or a set that loses to a clear, shows in the status readback on the first cycle after the write. Each such case is forced with a level trigger and with an edge timed to land exactly on the clearing write. A corrupted control field shows at once, either in readback or at padOe. It can also show as pending flags that should not appear, so each gating and unused-code case is followed by a status read.

// File: rtl/gpio_event_pkg.sv
package gpio_event_pkg;
  localparam int MAX_LINES = 32;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int CFG_W     = 8;

  // control word bit positions
  localparam int BIT_OUT_EN = 0;
  localparam int BIT_IN_EN  = 1;
  localparam int BIT_BUF_EN = 2;
  localparam int BIT_INT_EN = 3;
  localparam int TRIG_LSB   = 5;
  localparam logic [CFG_W-1:0] CFG_MASK = 8'hEF;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 8'h80;

  typedef enum logic [2:0] {
    TRIG_HIGH = 3'd0,
    TRIG_LOW  = 3'd1,
    TRIG_RISE = 3'd2,
    TRIG_FALL = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 clrValid;
    logic [MAX_LINES-1:0] clrBits;
  } clr_strobe_t;
endpackage

// File: rtl/gpio_event_regs.sv
module gpio_event_regs
  import gpio_event_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    psel,
  input  logic                    penable,
  input  logic                    pwrite,
  input  logic [ADDR_W-1:0]       paddr,
  input  logic [DATA_W-1:0]       pwdata,
  output logic [DATA_W-1:0]       prdata,
  input  logic [NUM_LINES-1:0]    pendQ,
  output clr_strobe_t             strobe,
  output logic [NUM_LINES-1:0]    outEn,
  output logic [NUM_LINES-1:0]    inEn,
  output logic [NUM_LINES-1:0]    bufEn,
  output logic [NUM_LINES-1:0]    intEn,
  output logic [NUM_LINES-1:0][2:0] trig
);
  localparam int IDX_W = 5;

  logic wrAcc;
  logic ctrlSpace;
  logic [IDX_W-1:0] idx;
  logic [CFG_W-1:0] cfgQ [NUM_LINES];

  assign wrAcc     = psel && penable && pwrite;
  assign ctrlSpace = (paddr[ADDR_W-1] == 1'b0) && (paddr[1:0] == 2'b00);
  assign idx       = paddr[IDX_W+1:2];

  always_comb begin
    strobe = '0;
    strobe.clrValid = wrAcc && (paddr == STATUS_ADDR);
    strobe.clrBits[NUM_LINES-1:0] = pwdata[NUM_LINES-1:0];
  end

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_cfg
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(4 * i);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) cfgQ[i] <= '0;
        else if (wrAcc && paddr == MY_ADDR) cfgQ[i] <= pwdata[CFG_W-1:0] & CFG_MASK;
      end
      assign outEn[i] = cfgQ[i][BIT_OUT_EN];
      assign inEn[i]  = cfgQ[i][BIT_IN_EN];
      assign bufEn[i] = cfgQ[i][BIT_BUF_EN];
      assign intEn[i] = cfgQ[i][BIT_INT_EN];
      assign trig[i]  = cfgQ[i][TRIG_LSB+2:TRIG_LSB];

      // a write to this control word is visible on the next cycle
      assert_cfg_write_R3: assert property (@(posedge clk) disable iff (!rstN)
        (wrAcc && paddr == MY_ADDR) |=> (cfgQ[i] == ($past(pwdata[CFG_W-1:0]) & CFG_MASK)));
    end
  endgenerate

  always_comb begin
    prdata = '0;
    if (paddr == STATUS_ADDR) begin
      prdata[NUM_LINES-1:0] = pendQ;
    end else if (ctrlSpace && int'(idx) < NUM_LINES) begin
      prdata[CFG_W-1:0] = cfgQ[idx];
    end
  end
endmodule

// File: rtl/gpio_event_dp.sv
module gpio_event_dp
  import gpio_event_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_LINES-1:0]      padIn,
  input  logic [NUM_LINES-1:0]      inEn,
  input  logic [NUM_LINES-1:0]      intEn,
  input  logic [NUM_LINES-1:0][2:0] trig,
  input  clr_strobe_t               strobe,
  output logic [NUM_LINES-1:0]      pendQ
);
  logic [NUM_LINES-1:0] syncA, syncB, prevQ;
  logic [NUM_LINES-1:0] setEv, clrMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  assign clrMask = strobe.clrValid ? strobe.clrBits[NUM_LINES-1:0] : '0;

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic hit;
      always_comb begin
        case (trig[i])
          TRIG_HIGH: hit = syncB[i];
          TRIG_LOW:  hit = !syncB[i];
          TRIG_RISE: hit = syncB[i] && !prevQ[i];
          TRIG_FALL: hit = !syncB[i] && prevQ[i];
          TRIG_BOTH: hit = syncB[i] != prevQ[i];
          default:   hit = 1'b0;
        endcase
      end
      assign setEv[i] = hit && intEn[i] && inEn[i];

      assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
        (clrMask[i] && !setEv[i]) |=> !pendQ[i]);
      assert_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
        (!(intEn[i] && inEn[i]) && !pendQ[i]) |=> !pendQ[i]);
      assert_code_R8: assert property (@(posedge clk) disable iff (!rstN)
        $rose(pendQ[i]) |-> ($past(trig[i]) <= 3'd4));
      assert_level_R9: assert property (@(posedge clk) disable iff (!rstN)
        (trig[i] == TRIG_HIGH && syncB[i] && intEn[i] && inEn[i]) |=> pendQ[i]);
    end
  endgenerate

  // set takes priority over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~clrMask) | setEv;
  end
endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit
  import gpio_event_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [7:0]           paddr,
  input  logic [31:0]          pwdata,
  output logic [31:0]          prdata,
  input  logic [NUM_LINES-1:0] padIn,
  output logic [NUM_LINES-1:0] padOe,
  output logic [NUM_LINES-1:0] irqVec,
  output logic                 irqAny
);
  logic [NUM_LINES-1:0]      pendQ, outEn, inEn, bufEn, intEn;
  logic [NUM_LINES-1:0][2:0] trig;
  clr_strobe_t               strobe;

  gpio_event_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pendQ(pendQ),
    .strobe(strobe), .outEn(outEn), .inEn(inEn), .bufEn(bufEn),
    .intEn(intEn), .trig(trig)
  );

  gpio_event_dp #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .padIn(padIn), .inEn(inEn), .intEn(intEn),
    .trig(trig), .strobe(strobe), .pendQ(pendQ)
  );

  assign padOe  = outEn & bufEn;
  assign irqVec = pendQ;
  assign irqAny = |pendQ;
endmodule

// File: tb/sim_gpio_event_unit.sv
`timescale 1ns/1ps
module sim_gpio_event_unit;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [N-1:0] padIn = '0;
  logic [N-1:0] padOe, irqVec;
  logic irqAny;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_event_unit #(.NUM_LINES(N)) u0 (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .padIn(padIn),
    .padOe(padOe), .irqVec(irqVec), .irqAny(irqAny)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    psel = 0; penable = 0;
  endtask

  // input drive at a negedge, then three rising edges until visible
  task automatic waitLat();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] cfgAddr(input int line);
    return 8'(4 * line);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R2 irqAny", 32'(irqAny), 0);
    chk("R2 irqVec", irqVec, 0);
    chk("R2 padOe", padOe, 0);
    busRead(8'h80, d); chk("R2 status", d, 0);
    busRead(cfgAddr(9), d); chk("R2 ctrl9", d, 0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    busWrite(cfgAddr(5), 32'hFFFF_FFFF);
    busRead(cfgAddr(5), d); chk("R3 readback", d, 32'h0000_00EF);
    chk("R4 oe both", 32'(padOe[5]), 1);
    busWrite(cfgAddr(5), 32'h1);
    chk("R4 oe out only", 32'(padOe[5]), 0);
    busWrite(cfgAddr(5), 32'h4);
    chk("R4 oe buf only", 32'(padOe[5]), 0);
    busWrite(cfgAddr(5), 32'h5);
    chk("R4 oe on", padOe, 32'h20);
    busWrite(cfgAddr(5), 32'h0);
    busRead(8'h84, d); chk("R1 unmapped", d, 0);
    busRead(8'h16, d); chk("R1 misaligned", d, 0);
    busWrite(cfgAddr(31), 32'h0000_00A3);
    busRead(cfgAddr(31), d); chk("R1 ctrl31", d, 32'hA3);
    busWrite(cfgAddr(31), 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    busWrite(cfgAddr(3), 32'h4A);
    @(negedge clk); padIn[3] = 1;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R7 rise early", irqVec, 0);
    @(posedge clk); @(negedge clk);
    chk("R7 rise latency", irqVec, 32'h8);
    chk("R10 any", 32'(irqAny), 1);
    busWrite(8'h80, 32'h8);
    busRead(8'h80, d); chk("R6 clear", d, 0);
    @(negedge clk); padIn[3] = 0; waitLat();
    chk("R7 rise ignores fall", irqVec, 0);
    busWrite(cfgAddr(3), 32'h0);
  endtask

  task automatic t_fall();
    busWrite(cfgAddr(7), 32'h6A);
    @(negedge clk); padIn[7] = 1; waitLat();
    chk("R7 fall ignores rise", irqVec, 0);
    @(negedge clk); padIn[7] = 0; waitLat();
    chk("R7 fall", irqVec, 32'h80);
    busWrite(8'h80, 32'h80);
    chk("R6 clear fall", irqVec, 0);
    busWrite(cfgAddr(7), 32'h0);
  endtask

  task automatic t_both();
    logic [31:0] d;
    busWrite(cfgAddr(31), 32'h8A);
    @(negedge clk); padIn[31] = 1; waitLat();
    chk("R7 both rise", irqVec, 32'h8000_0000);
    busWrite(8'h80, 32'h8000_0000);
    @(negedge clk); padIn[31] = 0; waitLat();
    chk("R7 both fall", irqVec, 32'h8000_0000);
    busWrite(8'h80, 32'h8000_0000);
    // line 6: edge lands on the same clock as the clearing write
    busWrite(cfgAddr(6), 32'h8A);
    @(negedge clk); padIn[6] = 1; waitLat();
    chk("R7 both line6", irqVec, 32'h40);
    @(negedge clk); padIn[6] = 0;
    busWrite(8'h80, 32'h40);
    busRead(8'h80, d); chk("R9 set wins over clear", d, 32'h40);
    busWrite(8'h80, 32'h40);
    busRead(8'h80, d); chk("R6 clear after race", d, 0);
    busWrite(cfgAddr(6), 32'h0);
    busWrite(cfgAddr(31), 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    busWrite(cfgAddr(0), 32'h0A);
    @(negedge clk); padIn[0] = 1; waitLat();
    chk("R9 level high", irqVec, 32'h1);
    busWrite(8'h80, 32'h1);
    chk("R9 reassert after clear", irqVec, 32'h1);
    @(negedge clk); padIn[0] = 0; waitLat();
    busWrite(8'h80, 32'h1);
    chk("R9 level gone clears", irqVec, 0);
    busWrite(cfgAddr(0), 32'h0);
    busWrite(cfgAddr(1), 32'h2A);
    @(posedge clk); @(negedge clk);
    chk("R9 level low", irqVec, 32'h2);
    busWrite(cfgAddr(1), 32'h0);
    busWrite(8'h80, 32'h2);
    busRead(8'h80, d); chk("R9 level low off", d, 0);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    busWrite(cfgAddr(2), 32'h48);   // interrupt on, input off, rising
    @(negedge clk); padIn[2] = 1; waitLat();
    chk("R5 no input enable", irqVec, 0);
    @(negedge clk); padIn[2] = 0; waitLat();
    busWrite(cfgAddr(2), 32'h42);   // input on, interrupt off
    @(negedge clk); padIn[2] = 1; waitLat();
    busRead(8'h80, d); chk("R5 no interrupt enable", d, 0);
    busWrite(cfgAddr(2), 32'h02);   // level high, interrupt off, input high
    waitLat();
    chk("R5 level disabled", irqVec, 0);
    @(negedge clk); padIn[2] = 0;
    busWrite(cfgAddr(2), 32'h0);
  endtask

  task automatic t_unused();
    logic [31:0] d;
    for (int c = 5; c < 8; c++) begin
      busWrite(cfgAddr(4), 32'(c << 5) | 32'h0A);
      @(negedge clk); padIn[4] = 1; waitLat();
      @(negedge clk); padIn[4] = 0; waitLat();
      busRead(8'h80, d); chk("R8 unused code", d, 0);
    end
    busWrite(cfgAddr(4), 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    busWrite(cfgAddr(8), 32'h4A);
    busWrite(cfgAddr(9), 32'h4A);
    @(negedge clk); padIn[8] = 1; padIn[9] = 1; waitLat();
    chk("R10 vector", irqVec, 32'h300);
    busWrite(8'h80, 32'h0);
    busRead(8'h80, d); chk("R6 write zero keeps", d, 32'h300);
    busWrite(8'h80, 32'h100);
    busRead(8'h80, d); chk("R6 partial clear", d, 32'h200);
    chk("R10 any one left", 32'(irqAny), 1);
    busWrite(8'h80, 32'hFFFF_FFFF);
    chk("R10 any none", 32'(irqAny), 0);
    @(negedge clk); padIn[8] = 0; padIn[9] = 0;
    busWrite(cfgAddr(8), 32'h0);
    busWrite(cfgAddr(9), 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    t_reset();
    t_fields();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_gate();
    t_unused();
    t_w1c();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule